// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block behaves as a small serial EEPROM on a two-wire bus. A fast system clock oversamples the bus clock and data lines. The block recognises start and stop conditions, shifts bytes in and out, and acknowledges by pulling the data line low. Behind the protocol engine sit a byte array, an address counter and a page buffer.

A master can write one byte or a burst of bytes within one page. A stop after at least one data byte starts a timed internal write cycle. During that cycle the buffered bytes are committed to the array, and the bus is ignored completely. A master can therefore poll for the end of the cycle by sending a device select until it is acknowledged. Reads may be random (a write select and an address, then a repeated start), current-address, or sequential. A configuration input selects how much of the upper array is protected against writes.

The only data path is the serial bus itself, so there is no valid/ready interface. The slave never stretches the clock, and the master paces every bit. Pad drivers stay outside the block. The block asserts `sda_drive_low_o` to pull the open-drain data line low, and the bus wire is the wired-AND of all drivers.

Top module: `eep_slave`

## Requirements
- R1: A start condition is SDA falling while SCL is high. Outside a write cycle, a start in any state aborts the current command and begins reception of a new device select byte.
- R2: The device select byte is 1010, then the three `CHIP_SEL` bits, then R/W (1 = read), sent MSB first. On a match the block pulls SDA low for the 9th clock. On a mismatch it does not acknowledge and it idles until the next start.
- R3: SDA is sampled on SCL rising. The block changes its SDA drive only while SCL is low. An acknowledge is held from the SCL fall after the 8th bit until the SCL fall after the 9th bit.
- R4: A write select is followed by two acknowledged address bytes, MSB first, of which the low `ADDR_W` bits are used. Each data byte is acknowledged and goes to the current address. After each data byte the low `PAGE_W` bits of the address increment and wrap inside the page; the default page is 32 bytes.
- R5: A stop after at least one complete data byte starts the internal write cycle. A stop after only the address bytes just loads the address counter, starts no cycle, and the block acknowledges again at once.
- R6: For `WR_CYCLES` clocks after the launching stop, the block ignores the bus and acknowledges nothing. After the cycle ends, the written bytes read back.
- R7: A random read returns the byte at the address that was just loaded.
- R8: A read select uses the address counter. The counter advances after each byte sent, and in sequential reads it wraps from the top address to address 0.
- R9: When the master does not acknowledge a read byte, the block releases SDA and sends nothing more until a start. A stop then leaves it in standby.
- R10: `protect_sel_i` selects the protected region: 0 none, 1 top quarter, 2 top half, 3 top three quarters, 4 to 7 the whole array. Data bytes aimed at a protected address are still acknowledged, but the array keeps its old value.
- R11: After reset, SDA is released and the block waits for a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_drive_low_o | output | 1 | 1 pulls the data line low; 0 releases it |
| protect_sel_i | input | 3 | Write-protect region code |

## Verification
The bench writes the last two bytes of a page and then two more. A design that did not wrap inside the page would spill into the next page, so the read-back at the page start would show stale data. It reads sequentially across the top address; a counter that saturated or stopped there would return the top byte twice instead of address 0. It polls during the write cycle, where a block that kept watching the bus would acknowledge early. It stops after only an address, where a design that launched a write cycle would refuse the very next select. Writes under each protection code probe the boundary addresses: the wrong comparison either corrupts a protected byte or blocks an unprotected one. A restart in the middle of an address byte checks that the bit count resynchronises.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_ACK,
    ST_RDAT,
    ST_RACK,
    ST_BUSY
  } eep_state_e;

  // Protected when the address quarter plus the protected quarter count reaches four.
  function automatic logic in_protect(input logic [1:0] quarter, input logic [2:0] sel);
    logic [2:0] q;
    q = sel[2] ? 3'd4 : sel;
    return (({1'b0, quarter} + q) >= 3'd4);
  endfunction

endpackage

// File: rtl/eep_bus_sense.sv
module eep_bus_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [2:0] scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  assign scl_o      = scl_q[1];
  assign sda_o      = sda_q[1];
  assign scl_rise_o = scl_q[1] & ~scl_q[2];
  assign scl_fall_o = ~scl_q[1] & scl_q[2];
  assign start_o    = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  assign stop_o     = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 2 ** ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  assign rdata_o = mem[addr_i];
endmodule

// File: rtl/eep_wcycle.sv
module eep_wcycle #(
  parameter int WR_CYCLES = 500000,
  parameter int PAGE_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_i,
  output logic              busy_o,
  output logic              commit_o,
  output logic [PAGE_W-1:0] idx_o
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);
  localparam int PAGE  = 2 ** PAGE_W;

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (launch_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (cnt_q == CNT_W'(WR_CYCLES - 1)) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o   = busy_q;
  assign commit_o = busy_q && (cnt_q < CNT_W'(PAGE));
  assign idx_o    = cnt_q[PAGE_W-1:0];
endmodule

// File: rtl/eep_slave.sv
module eep_slave
  import eep_pkg::*;
#(
  parameter int         ADDR_W    = 11,
  parameter int         PAGE_W    = 5,
  parameter logic [2:0] CHIP_SEL  = 3'b000,
  parameter int         WR_CYCLES = 500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_drive_low_o,
  input  logic [2:0] protect_sel_i
);
  localparam int PAGE = 2 ** PAGE_W;

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  eep_bus_sense u_sense (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_lvl),
    .sda_o      (sda_lvl),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  eep_state_e        state_q, ret_q;
  logic [3:0]        bitcnt_q;
  logic [7:0]        shreg_q, ahi_q;
  logic [ADDR_W-1:0] addr_q;
  logic              drive_q, rack_q;
  logic [7:0]        pbuf [PAGE];
  logic [PAGE-1:0]   pvalid_q;

  logic              wc_busy, wc_commit, launch;
  logic [PAGE_W-1:0] wc_idx;

  assign launch = stop_det && (state_q != ST_BUSY) && (|pvalid_q);

  eep_wcycle #(.WR_CYCLES(WR_CYCLES), .PAGE_W(PAGE_W)) u_wc (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch_i (launch),
    .busy_o   (wc_busy),
    .commit_o (wc_commit),
    .idx_o    (wc_idx)
  );

  logic [ADDR_W-1:0] mem_addr;
  logic              mem_we;
  logic [7:0]        mem_rdata;

  assign mem_addr = (state_q == ST_BUSY) ? {addr_q[ADDR_W-1:PAGE_W], wc_idx} : addr_q;
  assign mem_we   = wc_commit && pvalid_q[wc_idx] &&
                    !in_protect(mem_addr[ADDR_W-1 -: 2], protect_sel_i);

  eep_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_arr (
    .clk     (clk),
    .we_i    (mem_we),
    .addr_i  (mem_addr),
    .wdata_i (pbuf[wc_idx]),
    .rdata_o (mem_rdata)
  );

  logic byte_done, sel_hit, store_data;
  assign byte_done  = scl_fall && (bitcnt_q == 4'd8);
  assign sel_hit    = (shreg_q[7:1] == {4'b1010, CHIP_SEL});
  assign store_data = byte_done && (state_q == ST_WDAT) && !start_det && !stop_det;

  always_ff @(posedge clk) begin
    if (store_data) pbuf[addr_q[PAGE_W-1:0]] <= shreg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      ret_q    <= ST_IDLE;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      ahi_q    <= '0;
      addr_q   <= '0;
      drive_q  <= 1'b0;
      rack_q   <= 1'b0;
      pvalid_q <= '0;
    end else if (state_q == ST_BUSY) begin
      if (!wc_busy) begin
        state_q  <= ST_IDLE;
        pvalid_q <= '0;
      end
    end else if (start_det) begin
      state_q  <= ST_DEV;
      bitcnt_q <= '0;
      drive_q  <= 1'b0;
      pvalid_q <= '0;
    end else if (stop_det) begin
      drive_q <= 1'b0;
      state_q <= launch ? ST_BUSY : ST_IDLE;
    end else begin
      case (state_q)
        ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
          if (scl_rise && bitcnt_q < 4'd8) begin
            shreg_q  <= {shreg_q[6:0], sda_lvl};
            bitcnt_q <= bitcnt_q + 1'b1;
          end else if (byte_done) begin
            bitcnt_q <= '0;
            drive_q  <= 1'b1;
            state_q  <= ST_ACK;
            case (state_q)
              ST_DEV: begin
                if (sel_hit) ret_q <= shreg_q[0] ? ST_RDAT : ST_AHI;
                else begin
                  drive_q <= 1'b0;
                  state_q <= ST_IDLE;
                end
              end
              ST_AHI: begin
                ahi_q <= shreg_q;
                ret_q <= ST_ALO;
              end
              ST_ALO: begin
                addr_q <= ADDR_W'({ahi_q, shreg_q});
                ret_q  <= ST_WDAT;
              end
              default: begin
                pvalid_q[addr_q[PAGE_W-1:0]] <= 1'b1;
                addr_q <= {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + 1'b1};
                ret_q  <= ST_WDAT;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            state_q  <= ret_q;
            bitcnt_q <= '0;
            drive_q  <= 1'b0;
            if (ret_q == ST_RDAT) begin
              shreg_q <= mem_rdata;
              drive_q <= ~mem_rdata[7];
              addr_q  <= addr_q + 1'b1;
            end
          end
        end
        ST_RDAT: begin
          if (scl_fall) begin
            if (bitcnt_q == 4'd7) begin
              drive_q  <= 1'b0;
              bitcnt_q <= '0;
              state_q  <= ST_RACK;
            end else begin
              shreg_q  <= {shreg_q[6:0], 1'b0};
              drive_q  <= ~shreg_q[6];
              bitcnt_q <= bitcnt_q + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) rack_q <= ~sda_lvl;
          else if (scl_fall) begin
            if (rack_q) begin
              state_q <= ST_RDAT;
              shreg_q <= mem_rdata;
              drive_q <= ~mem_rdata[7];
              addr_q  <= addr_q + 1'b1;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_drive_low_o = drive_q;

  // R3
  sda_change_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_q != $past(drive_q)) |-> !$past(scl_lvl));

  // R6
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BUSY) |-> !drive_q);

  // R5
  we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (state_q == ST_BUSY));

  // R5
  busy_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wc_busy) |-> $past(stop_det));

  // R10
  protect_sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && protect_sel_i[2]) |-> 1'b0);
endmodule

// File: tb/eep_slave_tb_top.sv
module eep_slave_tb_top;
  localparam int         AW   = 11;
  localparam logic [2:0] CHIP = 3'b010;
  localparam int         WRC  = 300;
  localparam int         Q    = 10;
  localparam logic [7:0] WSEL = {4'b1010, CHIP, 1'b0};
  localparam logic [7:0] RSEL = {4'b1010, CHIP, 1'b1};

  // {address, data} pairs: byte write, then random read back
  localparam logic [18:0] VEC [6] = '{
    {11'h000, 8'hA5}, {11'h001, 8'h3C}, {11'h7FF, 8'hE1},
    {11'h123, 8'h5A}, {11'h600, 8'h77}, {11'h400, 8'h99}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic [2:0] prot = 3'd0;
  logic drv, sda_line;
  int checks = 0, errors = 0, r3_viol = 0;
  logic [7:0] rbuf [4];
  logic ackv;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~drv;

  eep_slave #(.ADDR_W(AW), .PAGE_W(5), .CHIP_SEL(CHIP), .WR_CYCLES(WRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_drive_low_o(drv), .protect_sel_i(prot)
  );

  // R3 monitor: the slave must not change its drive while SCL is high
  logic drv_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && drv !== drv_prev && scl) r3_viol++;
    drv_prev <= drv;
  end

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); ack = ~sda_line; wq(); scl = 1'b0; wq();
  endtask

  task automatic send_chk(input logic [7:0] b, input logic exp_ack, input string req);
    logic a;
    send(b, a);
    check(a === exp_ack, req, {15'd0, a}, {15'd0, exp_ack});
  endtask

  task automatic recv(input logic nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wq(); scl = 1'b1; wq(); b = {b[6:0], sda_line}; wq(); scl = 1'b0; wq();
    end
    sda_m = nack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq(); sda_m = 1'b1;
  endtask

  task automatic set_addr(input logic [10:0] a);
    i2c_start();
    send_chk(WSEL, 1'b1, "R2");
    send_chk({5'd0, a[10:8]}, 1'b1, "R4");
    send_chk(a[7:0], 1'b1, "R4");
  endtask

  task automatic read_cur(input int n);
    i2c_start();
    send_chk(RSEL, 1'b1, "R2");
    for (int i = 0; i < n; i++) recv(i == n - 1, rbuf[i]);
    i2c_stop();
  endtask

  task automatic rand_read(input logic [10:0] a, input int n);
    set_addr(a);
    read_cur(n);
  endtask

  task automatic byte_write(input logic [10:0] a, input logic [7:0] d, input string req);
    set_addr(a);
    send_chk(d, 1'b1, req);
    i2c_stop();
  endtask

  task automatic wait_wc(); repeat (WRC + 20) @(negedge clk); endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R11 reset state
    check(drv === 1'b0, "R11", {15'd0, drv}, 16'd0);

    // R2 non-matching select is not acknowledged
    i2c_start();
    send_chk({4'b1010, 3'b011, 1'b0}, 1'b0, "R2");
    i2c_stop();

    // Table walk: byte write, poll during cycle, random read back
    for (int i = 0; i < 6; i++) begin
      byte_write(VEC[i][18:8], VEC[i][7:0], "R4");
      i2c_start();
      send(WSEL, ackv);
      check(ackv === 1'b0, "R6", {15'd0, ackv}, 16'd0);
      i2c_stop();
      wait_wc();
      rand_read(VEC[i][18:8], 1);
      check(rbuf[0] === VEC[i][7:0], "R7", {8'd0, rbuf[0]}, {8'd0, VEC[i][7:0]});
    end

    // R4 page write wraps inside the page
    set_addr(11'h05E);
    for (int i = 0; i < 4; i++) send_chk(8'h10 + 8'(i), 1'b1, "R4");
    i2c_stop();
    wait_wc();
    rand_read(11'h05E, 2);
    check(rbuf[0] === 8'h10 && rbuf[1] === 8'h11, "R4", {rbuf[0], rbuf[1]}, 16'h1011);
    rand_read(11'h040, 2);
    check(rbuf[0] === 8'h12 && rbuf[1] === 8'h13, "R4", {rbuf[0], rbuf[1]}, 16'h1213);

    // R8 sequential read wraps top to 0, then current read continues
    rand_read(11'h7FF, 2);
    check(rbuf[0] === 8'hE1 && rbuf[1] === 8'hA5, "R8", {rbuf[0], rbuf[1]}, 16'hE1A5);
    read_cur(1);
    check(rbuf[0] === 8'h3C, "R8", {8'd0, rbuf[0]}, 16'h003C);

    // R5 address-only stop starts no write cycle
    set_addr(11'h123);
    i2c_stop();
    read_cur(1);
    check(rbuf[0] === 8'h5A, "R5", {8'd0, rbuf[0]}, 16'h005A);

    // R1 restart in the middle of an address byte
    i2c_start();
    send_chk(WSEL, 1'b1, "R2");
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    set_addr(11'h400);
    read_cur(1);
    check(rbuf[0] === 8'h99, "R1", {8'd0, rbuf[0]}, 16'h0099);

    // R10 protection regions
    prot = 3'd1;
    byte_write(11'h600, 8'h11, "R10"); wait_wc();
    rand_read(11'h600, 1);
    check(rbuf[0] === 8'h77, "R10", {8'd0, rbuf[0]}, 16'h0077);
    byte_write(11'h400, 8'h22, "R10"); wait_wc();
    rand_read(11'h400, 1);
    check(rbuf[0] === 8'h22, "R10", {8'd0, rbuf[0]}, 16'h0022);
    prot = 3'd2;
    byte_write(11'h400, 8'h33, "R10"); wait_wc();
    rand_read(11'h400, 1);
    check(rbuf[0] === 8'h22, "R10", {8'd0, rbuf[0]}, 16'h0022);
    prot = 3'd3;
    byte_write(11'h1FF, 8'h66, "R10"); wait_wc();
    rand_read(11'h1FF, 1);
    check(rbuf[0] === 8'h66, "R10", {8'd0, rbuf[0]}, 16'h0066);
    prot = 3'd4;
    byte_write(11'h000, 8'h44, "R10"); wait_wc();
    rand_read(11'h000, 1);
    check(rbuf[0] === 8'hA5, "R10", {8'd0, rbuf[0]}, 16'h00A5);
    prot = 3'd0;

    // R9 after a master nack the slave stays off the line
    set_addr(11'h001);
    i2c_start();
    send_chk(RSEL, 1'b1, "R2");
    recv(1'b1, rbuf[0]);
    check(rbuf[0] === 8'h3C, "R9", {8'd0, rbuf[0]}, 16'h003C);
    for (int i = 0; i < 2; i++) begin
      wq(); scl = 1'b1; wq();
      check(sda_line === 1'b1, "R9", {15'd0, sda_line}, 16'd1);
      wq(); scl = 1'b0; wq();
    end
    i2c_stop();
    i2c_start();
    send_chk(RSEL, 1'b1, "R9");
    recv(1'b1, rbuf[0]);
    i2c_stop();

    // R3 drive never changed while SCL was high
    check(r3_viol == 0, "R3", 16'(r3_viol), 16'd0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule